// File: doc/BRIEF.md
# Paged address translation unit

This unit turns a 32-bit virtual address into a physical address. It uses a flat page table in memory, described by two configuration registers: a table base address and a table length counted in entries. Each request carries a virtual address and a one-hot code for the kind of access. The unit first checks the page number against the table length. It then looks in a four-entry, fully associative translation cache. On a miss it reads the single-word table entry through a simple read port. Before it answers, it checks the access kind against the entry's permission bits.

Every accepted request produces exactly one response. The response is either the physical address with an ok status or a zero address with a fault status. An invalidate input empties the translation cache. If the invalidate arrives while a table read is outstanding, the read still completes and answers its request, but the fetched entry is discarded.

Top module: `xl_unit`

## Requirements
- R1: After reset `req_ready_o` is 1, `rsp_valid_o` and `mem_req_o` are 0, and the translation cache is empty, so the first access to any page issues a table read.
- R2: A page number (va[31:12]) greater than or equal to the table length register gives status 1 (out of bounds) with address 0, and no table read is made. This applies even when the page is cached.
- R3: On a cache miss exactly one table read is made, at address base + 4 × page number, and the address holds steady until `mem_ack_i`.
- R4: With status 0 the physical address is entry bits 31:12 followed by va bits 11:0. Entry bits 11:3 have no effect.
- R5: Permission bits are entry bits 2:0 and use bits are `req_use_i`: bit 2 read, bit 1 write, bit 0 execute. A use bit that is not granted gives status 2 with address 0. Out of bounds takes priority over a permission fault.
- R6: A request whose page is cached makes no table read and is checked against the cached permission bits.
- R7: A one-cycle `tlb_flush_i` while no table read is pending invalidates every cached entry.
- R8: `tlb_flush_i` during a table read does not disturb that request's response. The fetched entry is not cached, and all earlier entries are invalidated.
- R9: Fills go to the four slots in round-robin order, so a fifth distinct page evicts the oldest fill while the other three still hit.
- R10: `req_ready_o` is high only when the unit is idle and no flush is being requested. Each accepted request yields exactly one response, and `rsp_valid_o` is high for one cycle.
- R11: A table entry is cached even when the request that fetched it faulted on permissions, so a later permitted access to that page hits.
- R12: A configuration write with `cfg_sel_i` = 0 loads the table base, and with `cfg_sel_i` = 1 loads the table length from `cfg_wdata_i[20:0]`. The new value governs the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | 0 selects table base, 1 selects table length |
| cfg_wdata_i | input | 32 | Configuration write data |
| tlb_flush_i | input | 1 | Invalidate all cached translations |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Unit can accept a request |
| req_va_i | input | 32 | Virtual address |
| req_use_i | input | 3 | One-hot access kind (read, write, execute) |
| rsp_valid_o | output | 1 | Response valid, one-cycle pulse |
| rsp_pa_o | output | 32 | Physical address, zero on a fault |
| rsp_status_o | output | 2 | 0 ok, 1 out of bounds, 2 permission fault |
| mem_req_o | output | 1 | Table read request |
| mem_addr_o | output | 32 | Table read address |
| mem_ack_i | input | 1 | Table read data valid |
| mem_rdata_i | input | 32 | Table entry |

## Verification
The bench walks the cache through a complete round-robin cycle and then revisits pages. A design with the wrong replacement order would turn expected hits into misses, visible as unexpected table reads. It probes the bounds edge, where the page number equals the table length, and a cached page whose number moves out of bounds after the length is reduced. A design that trusts its cache or uses a strict greater-than compare would return an address there. It raises an invalidate in the middle of a table read. A design that kept that entry, or lost the response, would show a missing read on the revisit or a hung request. Permission faults on fills are followed by permitted hits to the same page, which catches a design that refuses to cache faulting entries.

// File: rtl/xl_pkg.sv
package xl_pkg;
  typedef enum logic [1:0] {
    XL_OK   = 2'd0,
    XL_OOB  = 2'd1,
    XL_PERM = 2'd2
  } xl_status_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_RESP  = 2'd2
  } xl_state_e;
endpackage

// File: rtl/xl_cfg.sv
module xl_cfg #(
  parameter int VA_W  = 32,
  parameter int VPN_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we_i,
  input  logic             cfg_sel_i,
  input  logic [VA_W-1:0]  cfg_wdata_i,
  output logic [VA_W-1:0]  base_o,
  output logic [VPN_W:0]   limit_o
);
  logic [VA_W-1:0] base_q, base_d;
  logic [VPN_W:0]  limit_q, limit_d;
  logic            base_en, limit_en;
  logic            unused_hi;

  assign unused_hi = ^cfg_wdata_i[VA_W-1:VPN_W+1];
  assign base_en   = cfg_we_i && !cfg_sel_i;
  assign limit_en  = cfg_we_i &&  cfg_sel_i;

  always_comb begin
    base_d  = base_en  ? cfg_wdata_i            : base_q;
    limit_d = limit_en ? cfg_wdata_i[VPN_W:0]   : limit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      limit_q <= '0;
    end else begin
      base_q  <= base_d;
      limit_q <= limit_d;
    end
  end

  assign base_o  = base_q;
  assign limit_o = limit_q;
endmodule

// File: rtl/xl_check.sv
module xl_check
  import xl_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int OFS_W = 12,
  parameter int RW    = 3
) (
  input  logic [VPN_W-1:0]       page_i,
  input  logic [VPN_W:0]         limit_i,
  input  logic [RW-1:0]          rights_i,
  input  logic [RW-1:0]          use_i,
  input  logic [VPN_W-1:0]       frame_i,
  input  logic [OFS_W-1:0]       ofs_i,
  output xl_status_e             status_o,
  output logic [VPN_W+OFS_W-1:0] pa_o
);
  logic oob, perm;

  always_comb begin
    oob  = ({1'b0, page_i} >= limit_i);
    perm = |(use_i & ~rights_i);
    if (oob)       status_o = XL_OOB;
    else if (perm) status_o = XL_PERM;
    else           status_o = XL_OK;
    pa_o = (status_o == XL_OK) ? {frame_i, ofs_i} : '0;
  end
endmodule

// File: rtl/xl_tlb.sv
module xl_tlb #(
  parameter int N     = 4,
  parameter int VPN_W = 20,
  parameter int RW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lk_page_i,
  output logic             hit_o,
  output logic [VPN_W-1:0] hit_frame_o,
  output logic [RW-1:0]    hit_rights_o,
  input  logic             fill_i,
  input  logic [VPN_W-1:0] fill_page_i,
  input  logic [VPN_W-1:0] fill_frame_i,
  input  logic [RW-1:0]    fill_rights_i,
  input  logic             clr_i
);
  localparam int PTR_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]     valid_q, valid_d;
  logic [VPN_W-1:0] tag_q   [N];
  logic [VPN_W-1:0] frame_q [N];
  logic [RW-1:0]    rights_q[N];
  logic [PTR_W-1:0] rr_q, rr_d;
  logic [N-1:0]     hit_vec;
  logic [N-1:0]     slot_we;

  for (genvar i = 0; i < N; i++) begin : g_slot
    assign hit_vec[i] = valid_q[i] && (tag_q[i] == lk_page_i);
    assign slot_we[i] = fill_i && (rr_q == PTR_W'(i));

    always_ff @(posedge clk) begin
      if (slot_we[i]) begin
        tag_q[i]    <= fill_page_i;
        frame_q[i]  <= fill_frame_i;
        rights_q[i] <= fill_rights_i;
      end
    end
  end

  always_comb begin
    hit_frame_o  = '0;
    hit_rights_o = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i]) begin
        hit_frame_o  = hit_frame_o  | frame_q[i];
        hit_rights_o = hit_rights_o | rights_q[i];
      end
    end
  end
  assign hit_o = |hit_vec;

  always_comb begin
    valid_d = valid_q;
    rr_d    = rr_q;
    if (clr_i) begin
      valid_d = '0;
    end else if (fill_i) begin
      valid_d = valid_q | slot_we;
      rr_d    = (rr_q == PTR_W'(N-1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else begin
      valid_q <= valid_d;
      rr_q    <= rr_d;
    end
  end

  AST_ONE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R9
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (valid_q == '0)); // R7
endmodule

// File: rtl/xl_unit.sv
module xl_unit
  import xl_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int OFS_W = 12,
  parameter int RW    = 3,
  parameter int TLB_N = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we_i,
  input  logic            cfg_sel_i,
  input  logic [VA_W-1:0] cfg_wdata_i,
  input  logic            tlb_flush_i,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic [VA_W-1:0] req_va_i,
  input  logic [RW-1:0]   req_use_i,
  output logic            rsp_valid_o,
  output logic [VA_W-1:0] rsp_pa_o,
  output logic [1:0]      rsp_status_o,
  output logic            mem_req_o,
  output logic [VA_W-1:0] mem_addr_o,
  input  logic            mem_ack_i,
  input  logic [VA_W-1:0] mem_rdata_i
);
  localparam int VPN_W = VA_W - OFS_W;
  localparam int PAD_W = VA_W - VPN_W - 2;

  xl_state_e       state_q, state_d;
  logic [VA_W-1:0] va_q, va_d;
  logic [RW-1:0]   use_q, use_d;
  logic [VA_W-1:0] pa_q, pa_d;
  xl_status_e      st_q, st_d;
  logic            fpend_q, fpend_d;

  logic [VA_W-1:0]  base;
  logic [VPN_W:0]   limit;
  logic             hit;
  logic [VPN_W-1:0] hit_frame;
  logic [RW-1:0]    hit_rights;
  logic             fetching, ack_now, drop_fill, fill_en, tlb_clr, req_fire;
  logic [VA_W-1:0]  chk_va;
  logic [RW-1:0]    chk_use, chk_rights;
  logic [VPN_W-1:0] chk_frame;
  xl_status_e       chk_status;
  logic [VA_W-1:0]  chk_pa;
  logic             unused_pte;

  assign unused_pte = ^mem_rdata_i[OFS_W-1:RW];

  xl_cfg #(.VA_W(VA_W), .VPN_W(VPN_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i),
    .cfg_wdata_i(cfg_wdata_i), .base_o(base), .limit_o(limit)
  );

  assign fetching    = (state_q == ST_FETCH);
  assign ack_now     = fetching && mem_ack_i;
  assign drop_fill   = fpend_q || tlb_flush_i;
  assign fill_en     = ack_now && !drop_fill;
  assign tlb_clr     = (tlb_flush_i && !fetching) || (ack_now && drop_fill);
  assign req_ready_o = (state_q == ST_IDLE) && !tlb_flush_i;
  assign req_fire    = req_valid_i && req_ready_o;

  xl_tlb #(.N(TLB_N), .VPN_W(VPN_W), .RW(RW)) u_tlb (
    .clk(clk), .rst_n(rst_n),
    .lk_page_i(req_va_i[VA_W-1:OFS_W]),
    .hit_o(hit), .hit_frame_o(hit_frame), .hit_rights_o(hit_rights),
    .fill_i(fill_en),
    .fill_page_i(va_q[VA_W-1:OFS_W]),
    .fill_frame_i(mem_rdata_i[VA_W-1:OFS_W]),
    .fill_rights_i(mem_rdata_i[RW-1:0]),
    .clr_i(tlb_clr)
  );

  always_comb begin
    chk_va     = fetching ? va_q  : req_va_i;
    chk_use    = fetching ? use_q : req_use_i;
    chk_rights = fetching ? mem_rdata_i[RW-1:0]        : hit_rights;
    chk_frame  = fetching ? mem_rdata_i[VA_W-1:OFS_W]  : hit_frame;
  end

  xl_check #(.VPN_W(VPN_W), .OFS_W(OFS_W), .RW(RW)) u_check (
    .page_i(chk_va[VA_W-1:OFS_W]), .limit_i(limit), .rights_i(chk_rights),
    .use_i(chk_use), .frame_i(chk_frame), .ofs_i(chk_va[OFS_W-1:0]),
    .status_o(chk_status), .pa_o(chk_pa)
  );

  always_comb begin
    state_d = state_q;
    va_d    = va_q;
    use_d   = use_q;
    pa_d    = pa_q;
    st_d    = st_q;
    fpend_d = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_fire) begin
          if (chk_status == XL_OOB || hit) begin
            state_d = ST_RESP;
            pa_d    = chk_pa;
            st_d    = chk_status;
          end else begin
            state_d = ST_FETCH;
            va_d    = req_va_i;
            use_d   = req_use_i;
          end
        end
      end
      ST_FETCH: begin
        fpend_d = fpend_q || tlb_flush_i;
        if (mem_ack_i) begin
          state_d = ST_RESP;
          pa_d    = chk_pa;
          st_d    = chk_status;
          fpend_d = 1'b0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      use_q   <= '0;
      pa_q    <= '0;
      st_q    <= XL_OK;
      fpend_q <= 1'b0;
    end else begin
      state_q <= state_d;
      va_q    <= va_d;
      use_q   <= use_d;
      pa_q    <= pa_d;
      st_q    <= st_d;
      fpend_q <= fpend_d;
    end
  end

  assign rsp_valid_o  = (state_q == ST_RESP);
  assign rsp_pa_o     = pa_q;
  assign rsp_status_o = st_q;
  assign mem_req_o    = fetching;
  assign mem_addr_o   = base + {{PAD_W{1'b0}}, va_q[VA_W-1:OFS_W], 2'b00};

  AST_OOB_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && chk_status == XL_OOB) |=> !mem_req_o); // R2
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o))); // R3
  AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && rsp_status_o != 2'd0) |-> (rsp_pa_o == '0)); // R5
  AST_NO_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o || rsp_valid_o) |-> !req_ready_o); // R10
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |=> !rsp_valid_o); // R10
  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_fire && !mem_ack_i) |=> !rsp_valid_o); // R10
endmodule

// File: tb/xl_unit_bench.sv
`timescale 1ns/1ps
module xl_unit_bench;
  localparam logic [31:0] BASE = 32'h0001_0000;
  localparam logic [2:0] U_R = 3'b100, U_W = 3'b010, U_X = 3'b001;
  localparam int NV = 14;
  // {va, use, expected status, expected table reads}
  localparam logic [37:0] VEC [0:NV-1] = '{
    {32'h0000_7123, U_R, 2'd0, 1'b1},
    {32'h0000_7FFF, U_W, 2'd0, 1'b0},
    {32'h0000_4010, U_W, 2'd2, 1'b1},
    {32'h0000_4020, U_R, 2'd0, 1'b0},
    {32'h0000_1ABC, U_X, 2'd0, 1'b1},
    {32'h0000_0000, U_R, 2'd2, 1'b1},
    {32'h0001_0000, U_R, 2'd1, 1'b0},
    {32'hFFFF_FFFF, U_W, 2'd1, 1'b0},
    {32'h0000_F008, U_X, 2'd0, 1'b1},
    {32'h0000_7004, U_R, 2'd0, 1'b1},
    {32'h0000_1ABD, U_X, 2'd0, 1'b0},
    {32'h0000_4444, U_R, 2'd0, 1'b1},
    {32'h0000_1000, U_X, 2'd0, 1'b1},
    {32'h0000_3000, U_R, 2'd2, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_we, cfg_sel, flush, req_valid, req_ready;
  logic [31:0] cfg_wdata, req_va;
  logic [2:0] req_use;
  logic rsp_valid;
  logic [31:0] rsp_pa;
  logic [1:0] rsp_status;
  logic mem_req, mem_ack;
  logic [31:0] mem_addr, mem_rdata;

  int checks = 0, fails = 0, reads = 0;
  logic [31:0] last_addr;
  logic [1:0] dly;
  bit done = 0;

  always #2.5 clk = ~clk;

  xl_unit u_xl_unit (
    .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .tlb_flush_i(flush), .req_valid_i(req_valid),
    .req_ready_o(req_ready), .req_va_i(req_va), .req_use_i(req_use),
    .rsp_valid_o(rsp_valid), .rsp_pa_o(rsp_pa), .rsp_status_o(rsp_status),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ack_i(mem_ack),
    .mem_rdata_i(mem_rdata)
  );

  function automatic logic [31:0] pte_of(logic [19:0] pg);
    return {pg ^ 20'hA5A5A, 9'h1AB, pg[2:0]};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; mem_rdata <= '0; dly <= '0; last_addr <= '0;
    end else begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
        if (dly == 2'd2) begin
          mem_ack   <= 1'b1;
          mem_rdata <= pte_of(20'((mem_addr - BASE) >> 2));
          last_addr <= mem_addr;
          reads     <= reads + 1;
          dly       <= '0;
        end else dly <= dly + 1'b1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  task automatic cfg_wr(input logic sel, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic xlate(input logic [31:0] va, input logic [2:0] use_c, input bit mid_flush,
                       output logic [1:0] st, output logic [31:0] pa, output int nrd);
    int r0;
    bit flushed;
    bit got;
    r0 = reads; flushed = 0; got = 0;
    @(negedge clk);
    req_valid = 1; req_va = va; req_use = use_c;
    @(negedge clk);
    req_valid = 0;
    for (int k = 0; k < 40; k++) begin
      flush = 0;
      if (rsp_valid) begin got = 1; break; end
      if (mem_req && req_ready) chk(0, "R10 ready while fetching", 1, 0);
      if (mid_flush && mem_req && !flushed) begin flush = 1; flushed = 1; end
      @(negedge clk);
    end
    flush = 0;
    chk(got, "R10 response delivered", 32'(got), 1);
    st = rsp_status; pa = rsp_pa;
    @(negedge clk);
    chk(!rsp_valid, "R10 response one cycle", 32'(rsp_valid), 0);
    nrd = reads - r0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [1:0] st;
    logic [31:0] pa, expa;
    int nrd;
    rst_n = 0; cfg_we = 0; cfg_sel = 0; cfg_wdata = '0; flush = 0;
    req_valid = 0; req_va = '0; req_use = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1, "R1 ready", 32'(req_ready), 1);
    chk(rsp_valid == 0, "R1 rsp_valid", 32'(rsp_valid), 0);
    chk(mem_req == 0, "R1 mem_req", 32'(mem_req), 0);
    // R12 configure base and length
    cfg_wr(0, BASE);
    cfg_wr(1, 32'd16);

    // Table: R1 first miss, R2, R3, R4, R5, R6, R9 round-robin, R11
    for (int i = 0; i < NV; i++) begin
      logic [31:0] va;
      logic [2:0] uc;
      logic [1:0] es;
      logic em;
      {va, uc, es, em} = VEC[i];
      xlate(va, uc, 0, st, pa, nrd);
      expa = (es == 2'd0) ? {va[31:12] ^ 20'hA5A5A, va[11:0]} : 32'h0;
      chk(st == es, "R2/R5 status", 32'(st), 32'(es));
      chk(pa == expa, "R4 physical address", pa, expa);
      chk(nrd == int'(em), "R6/R9/R11 table reads", 32'(nrd), 32'(em));
      if (em) chk(last_addr == BASE + {va[31:12], 2'b00}, "R3 fetch address",
                  last_addr, BASE + {va[31:12], 2'b00});
    end

    // R7: page 7 cached, flush, then it must miss
    xlate(32'h0000_7000, U_R, 0, st, pa, nrd);
    chk(nrd == 0, "R6 hit before flush", 32'(nrd), 0);
    @(negedge clk); flush = 1; @(negedge clk); flush = 0;
    xlate(32'h0000_7000, U_R, 0, st, pa, nrd);
    chk(nrd == 1, "R7 miss after flush", 32'(nrd), 1);

    // R8: flush during fetch of page 5
    xlate(32'h0000_5ABC, U_R, 1, st, pa, nrd);
    chk(st == 2'd0, "R8 status", 32'(st), 0);
    chk(pa == {20'h5 ^ 20'hA5A5A, 12'hABC}, "R8 address", pa, {20'h5 ^ 20'hA5A5A, 12'hABC});
    xlate(32'h0000_7000, U_R, 0, st, pa, nrd);
    chk(nrd == 1, "R8 older entry dropped", 32'(nrd), 1);
    xlate(32'h0000_5000, U_R, 0, st, pa, nrd);
    chk(nrd == 1, "R8 fetched entry dropped", 32'(nrd), 1);

    // R12 + R2: shrink length; cached page 7 now out of bounds
    cfg_wr(1, 32'd4);
    xlate(32'h0000_7000, U_R, 0, st, pa, nrd);
    chk(st == 2'd1, "R2 cached page out of bounds", 32'(st), 1);
    chk(nrd == 0, "R2 no read", 32'(nrd), 0);
    xlate(32'h0000_4000, U_R, 0, st, pa, nrd);
    chk(st == 2'd1, "R2 page equal to length", 32'(st), 1);
    xlate(32'h0000_3010, U_W, 0, st, pa, nrd);
    chk(st == 2'd0, "R12 in bounds write", 32'(st), 0);
    chk(pa == {20'h3 ^ 20'hA5A5A, 12'h010}, "R4 page 3", pa, {20'h3 ^ 20'hA5A5A, 12'h010});
    finish_run();
  end
endmodule